// File: doc/BRIEF.md
# Keyed Watchdog Timer with Scaled Compare

This block is a watchdog for an always-on power domain. A 31-bit counter advances on a one-cycle tick enable from a slow clock source. The counter can run unconditionally or only while the core is awake. A shift amount taken from the configuration register picks a 16-bit window of the counter. That window is compared against a programmable threshold. When the window reaches or passes the threshold, a sticky pending flag drives the interrupt line. Depending on configuration, the same event can also clear the counter and issue a one-cycle reset request to the system.

Software reaches the block through a plain 32-bit word register port. A write that changes state is honoured only when it immediately follows a write of a magic key. Any such honoured write closes the window again. Feeding the dog means an unlocked write of a second magic value to the feed register, which clears the counter.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the compare register reads 0xBEEF, the configuration, count and scaled count read 0, the key register reads 0, and neither irq nor rst_req is asserted.
- R2: The configuration register (offset 0x00) holds the scale in bits 3:0, reset enable in bit 8, zero-on-compare in bit 9, run-always in bit 12, run-while-awake in bit 13 and the pending flag in bit 28. All other bits read 0.
- R3: The count register (offset 0x08) reads the 31-bit counter with bit 31 at 0. The counter adds one on each tick while enabled and wraps from 0x7FFFFFFF to 0.
- R4: The scaled register (offset 0x10) reads the counter shifted right by the scale, truncated to 16 bits. Writes to it never change any state and do not consume an unlock.
- R5: When the scaled value is greater than or equal to the compare register (offset 0x20, 16 bits), the pending flag is set on the next edge. If zero-on-compare is set, the counter is also cleared on that edge.
- R6: With reset enable set, rst_req is high for exactly one cycle, in the cycle the pending flag first reflects a new compare event.
- R7: irq equals the pending flag at all times. The flag stays set until an unlocked configuration write clears bit 28.
- R8: A write of KEY_VAL to offset 0x1C opens the unlock window, and reading that offset returns the window state in bit 0. A write of any other value there leaves the window unchanged.
- R9: Writes to offsets 0x00, 0x08, 0x18 and 0x20 with the window closed change nothing. With the window open they take effect and close it.
- R10: An unlocked write of FEED_VAL to offset 0x18 clears the counter. Any other value written there only closes the window. Reading offset 0x18 returns 0.
- R11: The counter holds its value unless run-always is set, or run-while-awake is set while core_awake is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle count enable from the slow time base |
| core_awake | input | 1 | High while the core is awake |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, equal to the pending flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted counter, scale or threshold shows up at once in the count and scaled reads. It also shifts the cycle in which irq rises, which moves by at least one cycle. A wrong unlock flag appears as a protected write that lands or fails to land, and the next read of the affected register reveals it, as does the key readback in the following cycle. The reference model is compared against every output on every cycle while the read address sweeps all offsets, so any divergence is reported within a few cycles of the edge where it arises.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter logic [31:0] KEY_VAL  = 32'h0051F15E,
  parameter logic [31:0] FEED_VAL = 32'h0D09F00D,
  parameter logic [15:0] CMP_INIT = 16'hBEEF,
  parameter int          CNT_W    = 31,
  parameter int          VIEW_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        core_awake,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam logic [5:0] OFS_CFG  = 6'h00;
  localparam logic [5:0] OFS_CNT  = 6'h08;
  localparam logic [5:0] OFS_VIEW = 6'h10;
  localparam logic [5:0] OFS_FEED = 6'h18;
  localparam logic [5:0] OFS_KEY  = 6'h1C;
  localparam logic [5:0] OFS_CMP  = 6'h20;

  logic [CNT_W-1:0]  cnt;
  logic [VIEW_W-1:0] cmp;
  logic [3:0]        scale;
  logic              rst_en, zero_cmp, run_all, run_awake, pend;
  logic              unlock, hit_d;

  wire [CNT_W-1:0]  shifted = cnt >> scale;
  wire [VIEW_W-1:0] view    = shifted[VIEW_W-1:0];
  wire              hit     = view >= cmp;
  wire              run     = run_all | (run_awake & core_awake);

  wire wr_cfg  = bus_we & unlock & (bus_addr == OFS_CFG);
  wire wr_cnt  = bus_we & unlock & (bus_addr == OFS_CNT);
  wire wr_feed = bus_we & unlock & (bus_addr == OFS_FEED);
  wire wr_cmp  = bus_we & unlock & (bus_addr == OFS_CMP);
  wire wr_key  = bus_we & (bus_addr == OFS_KEY) & (bus_wdata == KEY_VAL);
  wire consume = wr_cfg | wr_cnt | wr_feed | wr_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= CMP_INIT;
      {scale, rst_en, zero_cmp, run_all, run_awake, pend} <= '0;
      unlock  <= 1'b0;
      hit_d   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      hit_d   <= hit;
      rst_req <= hit & ~hit_d & rst_en;

      if (wr_cnt)                                cnt <= bus_wdata[CNT_W-1:0];
      else if (wr_feed && bus_wdata == FEED_VAL) cnt <= '0;
      else if (hit && zero_cmp)                  cnt <= '0;
      else if (run && tick_en)                   cnt <= cnt + 1'b1;

      if (wr_cfg) begin
        scale     <= bus_wdata[3:0];
        rst_en    <= bus_wdata[8];
        zero_cmp  <= bus_wdata[9];
        run_all   <= bus_wdata[12];
        run_awake <= bus_wdata[13];
      end
      if (hit)         pend <= 1'b1;
      else if (wr_cfg) pend <= bus_wdata[28];

      if (wr_cmp) cmp <= bus_wdata[VIEW_W-1:0];

      if (consume)     unlock <= 1'b0;
      else if (wr_key) unlock <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CFG:  bus_rdata = {3'b0, pend, 14'b0, run_awake, run_all, 2'b0,
                             zero_cmp, rst_en, 4'b0, scale};
      OFS_CNT:  bus_rdata = 32'(cnt);
      OFS_VIEW: bus_rdata = 32'(view);
      OFS_KEY:  bus_rdata = {31'b0, unlock};
      OFS_CMP:  bus_rdata = 32'(cmp);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = pend;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [5:0]       bus_addr,
  input logic             irq,
  input logic             rst_req,
  input logic             unlock,
  input logic             run,
  input logic             hit,
  input logic             zero_cmp,
  input logic [CNT_W-1:0] cnt
);
  wire prot = bus_addr == 6'h00 || bus_addr == 6'h08 ||
              bus_addr == 6'h18 || bus_addr == 6'h20;

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R6
  rst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(bus_we && bus_addr == 6'h00) |=> irq);

  // R9
  unlock_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock && bus_we && prot |=> !unlock);

  // R8
  unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock && !(bus_we && bus_addr == 6'h1C) |=> !unlock);

  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !bus_we && !(hit && zero_cmp) |=> $stable(cnt));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq(irq), .rst_req(rst_req), .unlock(unlock), .run(run),
  .hit(hit), .zero_cmp(zero_cmp), .cnt(cnt)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam logic [31:0] KEY  = 32'h0051F15E;
  localparam logic [31:0] FEED = 32'h0D09F00D;

  logic clk = 0, rst_n = 0, tick_en = 0, core_awake = 0, bus_we = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, rst_req;
  int n_chk = 0, n_fail = 0, sweep = 0;

  always #4 clk = ~clk;

  wdt_keyed u_wdt_keyed (.*);

  // behavioural reference state
  longint m_cnt; int m_cmp, m_scale;
  bit m_rsten, m_zc, m_all, m_awake, m_pend, m_unl, m_prev_hit, m_rst;

  function automatic int m_view();
    return int'((m_cnt >> m_scale) % 65536);
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    case (a)
      6'h00: return (m_pend << 28) | (m_awake << 13) | (m_all << 12) |
                    (m_zc << 9) | (m_rsten << 8) | m_scale;
      6'h08: return 32'(m_cnt);
      6'h10: return 32'(m_view());
      6'h1C: return {31'b0, m_unl};
      6'h20: return 32'(m_cmp);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 'hBEEF; m_scale = 0;
      {m_rsten, m_zc, m_all, m_awake, m_pend, m_unl, m_prev_hit, m_rst} = '0;
    end else begin
      bit hit, ok, zc_old, en_old;
      hit = m_view() >= m_cmp;
      zc_old = m_zc;
      en_old = m_all || (m_awake && core_awake);
      ok = bus_we && m_unl &&
           (bus_addr == 6'h00 || bus_addr == 6'h08 || bus_addr == 6'h18 || bus_addr == 6'h20);
      m_rst = hit && !m_prev_hit && m_rsten;
      m_prev_hit = hit;
      if (ok && bus_addr == 6'h08) m_cnt = bus_wdata[30:0];
      else if (ok && bus_addr == 6'h18 && bus_wdata == FEED) m_cnt = 0;
      else if (hit && zc_old) m_cnt = 0;
      else if (en_old && tick_en) m_cnt = (m_cnt + 1) % (64'd1 << 31);
      if (ok && bus_addr == 6'h00) begin
        m_scale = bus_wdata[3:0]; m_rsten = bus_wdata[8]; m_zc = bus_wdata[9];
        m_all = bus_wdata[12]; m_awake = bus_wdata[13];
        if (!hit) m_pend = bus_wdata[28];
      end
      if (hit) m_pend = 1;
      if (ok && bus_addr == 6'h20) m_cmp = bus_wdata[15:0];
      if (ok) m_unl = 0;
      else if (bus_we && bus_addr == 6'h1C && bus_wdata == KEY) m_unl = 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", tag, bus_addr, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      string t;
      case (bus_addr)
        6'h00: t = "R2"; 6'h08: t = "R3"; 6'h10: t = "R4";
        6'h18: t = "R10"; 6'h1C: t = "R8"; default: t = "R5";
      endcase
      check(t, bus_rdata, m_read(bus_addr));
      check("R7", {31'b0, irq}, {31'b0, m_pend});
      check("R6", {31'b0, rst_req}, {31'b0, m_rst});
    end
  end

  task automatic idle(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_we = 0;
      tick_en = rnd ? 1'($urandom) : 1'b1;
      case (sweep % 6)
        0: bus_addr = 6'h00; 1: bus_addr = 6'h08; 2: bus_addr = 6'h10;
        3: bus_addr = 6'h18; 4: bus_addr = 6'h1C; default: bus_addr = 6'h20;
      endcase
      sweep++;
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 6'h1C;
  endtask

  task automatic kwr(logic [5:0] a, logic [31:0] d);
    wr(6'h1C, KEY);
    wr(a, d);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, full address sweep
    idle(12, 1);
    // R9 writes without key are ignored
    wr(6'h00, 32'h0000_3000);
    wr(6'h20, 32'h3);
    wr(6'h18, FEED);
    idle(12, 1);
    // R8 wrong key leaves window closed
    wr(6'h1C, 32'h1234);
    idle(3, 1);
    // R4 scaled write ignored and keeps the window
    wr(6'h1C, KEY);
    wr(6'h10, 32'hFFFF);
    idle(2, 0);
    wr(6'h20, 32'd20);
    // R3 / R11 run always, scale 0
    kwr(6'h00, 32'h0000_1000);
    idle(40, 0);
    // R7 clear pending while counting stopped
    kwr(6'h08, 32'd0);
    kwr(6'h00, 32'h0000_0000);
    idle(6, 1);
    // R5 / R6 zero-on-compare and reset request, scale 2
    kwr(6'h20, 32'd3);
    kwr(6'h00, 32'h0000_1302);
    idle(60, 1);
    // R10 feeding, wrong and right value
    kwr(6'h00, 32'h0000_1000);
    kwr(6'h20, 32'hFFFF);
    idle(10, 0);
    kwr(6'h18, 32'hDEAD);
    idle(6, 0);
    kwr(6'h18, FEED);
    idle(6, 0);
    // R11 gated by core_awake
    kwr(6'h00, 32'h0000_2000);
    core_awake = 0;
    idle(12, 0);
    core_awake = 1;
    idle(12, 1);
    // R3 wrap near the top, scale 15
    kwr(6'h08, 32'h7FFF_FFFC);
    kwr(6'h00, 32'h0000_100F);
    idle(18, 0);
    // R2 reserved bits read as zero
    kwr(6'h00, 32'hFFFF_FFFF);
    kwr(6'h00, 32'h0000_0000);
    idle(12, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule